// File: doc/BRIEF.md
# Lazy Context Register Save Controller

This controller sits next to a CPU register file and moves register state between the register file and per-context memory areas when a trap is taken and when it returns. Trap entry does not stall to copy the whole register file. The controller switches to the handler context and clears its per-register tracking. It then saves each register of the interrupted task into that task's memory area, either on demand when the handler first uses the register or through a background sweep that fills in the rest.

When the handler reads a register, or writes only part of it, the controller first loads the handler's own stored value from the handler area. Handler registers therefore carry their values from one invocation to the next. On return the controller walks the registers in ascending order and reloads every register it saved from the task area. In the persistent return mode it first writes each register the handler modified back to the handler area. A separate save command does that write-back on its own, without returning.

The pipeline presents one access per cycle with an index and two qualifiers, and holds it while `stall` is high. The register file has one combinational read port and one write port driven by this block; the surrounding logic must block pipeline access while a walk is running.

Top module: `lazy_ctx_saver`

## Requirements
- R1: After reset the block is idle, with `stall`, `mem_valid`, `nest_err` and `sweep_done` low. `trap_enter` in the idle state switches to the handler context and clears every saved, loaded and modified flag, so `sweep_done` is low again until the sweep has been redone.
- R2: While the handler context is active, an access to a register whose saved flag is clear holds `stall` high. Meanwhile it writes the register's current value to `task_base + 4*index`. The access proceeds only in a cycle after that write handshake.
- R3: A pending on-demand save or load is issued on the memory port ahead of any background sweep transfer.
- R4: An access with `acc_fetch` high (a read, or a partial write) to a register not yet loaded in this invocation first reads `hdl_base + 4*index` and writes that word into the register file before the access proceeds. A value the handler stored in an earlier invocation is therefore seen again.
- R5: The background sweep saves every register whose saved flag is clear, picking the lowest such index first. `sweep_done` is high while a handler context is active and all registers 1..NREG-1 are saved.
- R6: On `trap_return`, each register from 1 to NREG-1 whose saved flag is set is reloaded from `task_base + 4*index`, in ascending order. A register that was never saved is not reloaded, so any word placed in its task slot is ignored.
- R7: With `ret_persist` high at `trap_return`, each register the handler wrote is stored to `hdl_base + 4*index` just before its own reload. With `ret_persist` low the handler area is not written.
- R8: `save_cmd` in the active context writes every register the handler wrote to `hdl_base + 4*index` in ascending order, then returns to the active context.
- R9: `trap_enter` outside the idle state raises `nest_err` for one cycle on the next cycle and does not start a new switch or clear any flag.
- R10: Register 0 is never saved, loaded or restored. No transfer uses a slot-0 address, and the register file is never written at index 0.
- R11: A full write (`acc_write` high, `acc_fetch` low) never loads from the handler area. It marks the register as both modified and loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Pipeline register access present |
| acc_idx | input | IW | Index of the accessed register |
| acc_fetch | input | 1 | Access needs the old value (read or partial write) |
| acc_write | input | 1 | Access writes the register |
| stall | output | 1 | Hold the current access |
| trap_enter | input | 1 | Trap-entry strobe |
| trap_return | input | 1 | Trap-return strobe |
| ret_persist | input | 1 | Return mode: 1 persists handler writes, 0 discards them |
| save_cmd | input | 1 | Explicit handler-context save strobe |
| task_base | input | AW | Base address of the interrupted task area |
| hdl_base | input | AW | Base address of the handler area |
| nest_err | output | 1 | Trap entry while already in handler context |
| sweep_done | output | 1 | All task registers saved |
| rf_rd_idx | output | IW | Register file read index |
| rf_rd_data | input | XLEN | Register file read data |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | IW | Register file write index |
| rf_wr_data | output | XLEN | Register file write data |
| mem_valid | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | AW | Word address in bytes |
| mem_wdata | output | XLEN | Write data |
| mem_ready | input | 1 | Transfer accepted this cycle |
| mem_rdata | input | XLEN | Read data, valid with `mem_ready` |

## Verification
The bench builds the block at its default size: 32 registers of 32 bits and 32-bit addresses. That gives a 31-register sweep, long enough that demand saves, loads and full writes can be placed while most registers are still unsaved. The memory model can grant only chosen addresses, which holds the sweep back. That makes unsaved slots, priority over the sweep, and return with a partly saved context reachable in a fixed, predictable order.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_SAVE, ST_RET} state_t;
  typedef enum logic [2:0] {OP_NONE, OP_DSAVE, OP_DLOAD, OP_PWR, OP_RST, OP_SWEEP} op_t;
endpackage

// File: rtl/lcs_rst_sync.sv
module lcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/lcs_flags.sv
module lcs_flags #(
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            sv_set,
  input  logic [IW-1:0]   sv_idx,
  input  logic            ld_set,
  input  logic [IW-1:0]   ld_idx,
  input  logic            wr_set,
  input  logic [IW-1:0]   wr_idx,
  output logic [NREG-1:0] saved_o,
  output logic [NREG-1:0] loaded_o,
  output logic [NREG-1:0] modif_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_bit
    if (g == 0) begin : g_zero
      // index 0 is constant zero: treated as already saved and loaded
      assign saved_o[g]  = 1'b1;
      assign loaded_o[g] = 1'b1;
      assign modif_o[g]  = 1'b0;
    end else begin : g_reg
      logic sv_q, sv_d, ld_q, ld_d, md_q, md_d;

      always_comb begin
        sv_d = sv_q;
        ld_d = ld_q;
        md_d = md_q;
        if (clr) begin
          sv_d = 1'b0;
          ld_d = 1'b0;
          md_d = 1'b0;
        end else begin
          if (sv_set && sv_idx == IW'(g)) sv_d = 1'b1;
          if (ld_set && ld_idx == IW'(g)) ld_d = 1'b1;
          if (wr_set && wr_idx == IW'(g)) begin
            ld_d = 1'b1;
            md_d = 1'b1;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sv_q <= 1'b0;
          ld_q <= 1'b0;
          md_q <= 1'b0;
        end else begin
          sv_q <= sv_d;
          ld_q <= ld_d;
          md_q <= md_d;
        end
      end

      assign saved_o[g]  = sv_q;
      assign loaded_o[g] = ld_q;
      assign modif_o[g]  = md_q;
    end
  end
endmodule

// File: rtl/lcs_pick.sv
module lcs_pick #(
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] vec,
  output logic            found,
  output logic [IW-1:0]   idx
);
  // lowest index at or above 1 whose bit is clear
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NREG - 1; i >= 1; i--) begin
      if (!vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lazy_ctx_saver.sv
module lazy_ctx_saver
  import lcs_pkg::*;
#(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic [IW-1:0]   acc_idx,
  input  logic            acc_fetch,
  input  logic            acc_write,
  output logic            stall,
  input  logic            trap_enter,
  input  logic            trap_return,
  input  logic            ret_persist,
  input  logic            save_cmd,
  input  logic [AW-1:0]   task_base,
  input  logic [AW-1:0]   hdl_base,
  output logic            nest_err,
  output logic            sweep_done,
  output logic [IW-1:0]   rf_rd_idx,
  input  logic [XLEN-1:0] rf_rd_data,
  output logic            rf_wr_en,
  output logic [IW-1:0]   rf_wr_idx,
  output logic [XLEN-1:0] rf_wr_data,
  output logic            mem_valid,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata
);
  localparam logic [IW-1:0] LAST_IDX  = IW'(NREG - 1);
  localparam logic [IW-1:0] FIRST_IDX = IW'(1);

  logic            rst_q;
  state_t          st, st_n;
  logic [IW-1:0]   widx, widx_n;
  logic            ph, ph_n;
  logic            rmode, rmode_n;
  logic            nerr_q, nerr_n;
  logic            clr;
  op_t             op;
  logic [IW-1:0]   op_idx;
  logic [AW-1:0]   op_base;
  logic            hs, walk_busy;
  logic [NREG-1:0] saved_v, loaded_v, modif_v;
  logic            sw_found;
  logic [IW-1:0]   sw_idx;
  logic            sv_set, ld_set, wr_set;

  lcs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q));

  lcs_flags #(.NREG(NREG), .IW(IW)) u_flags (
    .clk(clk), .rst_n(rst_q), .clr(clr),
    .sv_set(sv_set), .sv_idx(op_idx),
    .ld_set(ld_set), .ld_idx(op_idx),
    .wr_set(wr_set), .wr_idx(acc_idx),
    .saved_o(saved_v), .loaded_o(loaded_v), .modif_o(modif_v)
  );

  lcs_pick #(.NREG(NREG), .IW(IW)) u_pick (
    .vec(saved_v), .found(sw_found), .idx(sw_idx)
  );

  // transfer selection: demand first, then walk steps, then sweep
  always_comb begin
    op      = OP_NONE;
    op_idx  = sw_idx;
    op_base = task_base;
    if (st == ST_ACTIVE) begin
      if (acc_valid && !saved_v[acc_idx]) begin
        op     = OP_DSAVE;
        op_idx = acc_idx;
      end else if (acc_valid && acc_fetch && !loaded_v[acc_idx]) begin
        op      = OP_DLOAD;
        op_idx  = acc_idx;
        op_base = hdl_base;
      end else if (sw_found) begin
        op = OP_SWEEP;
      end
    end else if (st == ST_SAVE || (st == ST_RET && rmode && !ph)) begin
      if (modif_v[widx]) begin
        op      = OP_PWR;
        op_idx  = widx;
        op_base = hdl_base;
      end
    end else if (st == ST_RET && ph && saved_v[widx]) begin
      op     = OP_RST;
      op_idx = widx;
    end
  end

  assign mem_valid  = (op != OP_NONE);
  assign mem_we     = (op == OP_DSAVE) || (op == OP_PWR) || (op == OP_SWEEP);
  assign mem_addr   = op_base + AW'({op_idx, 2'b00});
  assign rf_rd_idx  = op_idx;
  assign mem_wdata  = rf_rd_data;
  assign hs         = mem_valid && mem_ready;
  assign rf_wr_en   = hs && !mem_we;
  assign rf_wr_idx  = op_idx;
  assign rf_wr_data = mem_rdata;
  assign walk_busy  = (op == OP_PWR) || (op == OP_RST);

  assign stall = acc_valid &&
                 ((st == ST_ACTIVE && (op == OP_DSAVE || op == OP_DLOAD)) ||
                  st == ST_SAVE || st == ST_RET);

  assign sv_set = hs && (op == OP_DSAVE || op == OP_SWEEP);
  assign ld_set = hs && (op == OP_DLOAD);
  assign wr_set = (st == ST_ACTIVE) && acc_valid && acc_write && !stall;

  assign sweep_done = (st == ST_ACTIVE || st == ST_SAVE) && (&saved_v);
  assign nest_err   = nerr_q;

  always_comb begin
    st_n    = st;
    widx_n  = widx;
    ph_n    = ph;
    rmode_n = rmode;
    nerr_n  = 1'b0;
    clr     = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (trap_enter) begin
          st_n = ST_ACTIVE;
          clr  = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (trap_enter) begin
          nerr_n = 1'b1;
        end else if (trap_return) begin
          st_n    = ST_RET;
          widx_n  = FIRST_IDX;
          ph_n    = 1'b0;
          rmode_n = ret_persist;
        end else if (save_cmd) begin
          st_n   = ST_SAVE;
          widx_n = FIRST_IDX;
          ph_n   = 1'b0;
        end
      end
      default: begin
        nerr_n = trap_enter;
        if (!walk_busy || hs) begin
          if (st == ST_RET && !ph) begin
            ph_n = 1'b1;
          end else begin
            ph_n = 1'b0;
            if (widx == LAST_IDX) st_n = (st == ST_SAVE) ? ST_ACTIVE : ST_IDLE;
            else widx_n = widx + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st     <= ST_IDLE;
      widx   <= FIRST_IDX;
      ph     <= 1'b0;
      rmode  <= 1'b0;
      nerr_q <= 1'b0;
    end else begin
      st     <= st_n;
      widx   <= widx_n;
      ph     <= ph_n;
      rmode  <= rmode_n;
      nerr_q <= nerr_n;
    end
  end
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker
  import lcs_pkg::*;
#(
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_q,
  input state_t          st,
  input logic            acc_valid,
  input logic [IW-1:0]   acc_idx,
  input logic            acc_fetch,
  input logic            stall,
  input logic            trap_enter,
  input logic            nest_err,
  input logic            sweep_done,
  input logic            rf_wr_en,
  input logic [IW-1:0]   rf_wr_idx,
  input logic [NREG-1:0] saved_v,
  input logic [NREG-1:0] loaded_v
);
  AST_ACCESS_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_ACTIVE && acc_valid && !stall) |-> saved_v[acc_idx]); // R2

  AST_FETCH_BEFORE_USE: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_ACTIVE && acc_valid && acc_fetch && !stall) |-> loaded_v[acc_idx]); // R4

  AST_DONE_ALL_SAVED: assert property (@(posedge clk) disable iff (!rst_q)
    sweep_done |-> (&saved_v)); // R5

  AST_RESTORE_ONLY_SAVED: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_RET && rf_wr_en) |-> saved_v[rf_wr_idx]); // R6

  AST_NEST_FLAGGED: assert property (@(posedge clk) disable iff (!rst_q)
    (trap_enter && st != ST_IDLE) |=> (nest_err && st != ST_IDLE)); // R9

  AST_NO_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    rf_wr_en |-> (rf_wr_idx != '0)); // R10
endmodule

bind lazy_ctx_saver lcs_checker #(.NREG(NREG), .IW(IW)) u_chk (
  .clk(clk), .rst_q(rst_q), .st(st),
  .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_fetch(acc_fetch),
  .stall(stall), .trap_enter(trap_enter), .nest_err(nest_err),
  .sweep_done(sweep_done), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
  .saved_v(saved_v), .loaded_v(loaded_v)
);

// File: tb/lazy_ctx_saver_test.sv
`timescale 1ns/1ps
module lazy_ctx_saver_test;
  localparam int NREG = 32;
  localparam int IW   = 5;
  localparam logic [31:0] TB_TASK = 32'h0000_1000;
  localparam logic [31:0] TB_HDL  = 32'h0000_2000;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_fetch, acc_write, stall;
  logic [IW-1:0] acc_idx;
  logic trap_enter, trap_return, ret_persist, save_cmd;
  logic nest_err, sweep_done;
  logic [IW-1:0] rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data;
  logic rf_wr_en;
  logic mem_valid, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] rf [NREG];
  logic [31:0] task_m [NREG];
  logic [31:0] hdl_m [NREG];
  logic pw_en;
  logic [IW-1:0] pw_idx;
  logic [31:0] pw_data;
  int rdy_mode;
  logic [31:0] alw_a, alw_b;

  int n_chk = 0, n_fail = 0, hdl_reads = 0;
  logic q_we[$];
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  lazy_ctx_saver uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_fetch(acc_fetch), .acc_write(acc_write),
    .stall(stall), .trap_enter(trap_enter), .trap_return(trap_return),
    .ret_persist(ret_persist), .save_cmd(save_cmd),
    .task_base(TB_TASK), .hdl_base(TB_HDL),
    .nest_err(nest_err), .sweep_done(sweep_done),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  assign rf_rd_data = rf[rf_rd_idx];
  assign mem_ready  = (rdy_mode == 1) ||
                      (rdy_mode == 2 && mem_valid && (mem_addr == alw_a || mem_addr == alw_b));
  assign mem_rdata  = (mem_addr[15:12] == 4'h1) ? task_m[mem_addr[6:2]] :
                      (mem_addr[15:12] == 4'h2) ? hdl_m[mem_addr[6:2]] : 32'h0;

  always @(posedge clk) begin
    if (rf_wr_en) rf[rf_wr_idx] <= rf_wr_data;
    if (pw_en) rf[pw_idx] <= pw_data;
    if (mem_valid && mem_ready && mem_we) begin
      if (mem_addr[15:12] == 4'h1) task_m[mem_addr[6:2]] <= mem_wdata;
      else if (mem_addr[15:12] == 4'h2) hdl_m[mem_addr[6:2]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [31:0] a, input logic [31:0] d, input string tag);
    q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  // monitor: each accepted transfer, sampled between edges
  always begin
    @(negedge clk); #1;
    if (mem_valid && mem_ready) begin
      if (!mem_we && mem_addr[15:12] == 4'h2) hdl_reads++;
      if (mem_addr[6:2] == 5'd0) chk(1'b0, "R10 slot zero transfer", mem_addr, 32'h0);
      if (q_addr.size() > 0) begin
        logic ew; logic [31:0] ea, ed; string et;
        ew = q_we.pop_front(); ea = q_addr.pop_front(); ed = q_data.pop_front(); et = q_tag.pop_front();
        chk(mem_we == ew && mem_addr == ea, {et, " addr/dir"}, {mem_we, mem_addr[30:0]}, {ew, ea[30:0]});
        if (ew) chk(mem_wdata == ed, {et, " wdata"}, mem_wdata, ed);
      end
    end
  end

  task automatic access(input int idx, input logic f, input logic w, input logic [31:0] wv);
    acc_valid = 1'b1; acc_idx = IW'(idx); acc_fetch = f; acc_write = w;
    #1;
    while (stall) begin @(negedge clk); #1; end
    if (w) begin
      pw_en = 1'b1; pw_idx = IW'(idx);
      pw_data = (f) ? {rf[idx][31:8], wv[7:0]} : wv;
    end
    @(negedge clk);
    acc_valid = 1'b0; acc_fetch = 1'b0; acc_write = 1'b0; pw_en = 1'b0;
  endtask

  task automatic pulse_enter();
    trap_enter = 1'b1; @(negedge clk); trap_enter = 1'b0;
  endtask

  task automatic drain(input int extra);
    int guard = 0;
    while (q_addr.size() > 0 && guard < 500) begin @(negedge clk); guard++; end
    repeat (extra) @(negedge clk);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!sweep_done && guard < 300) begin @(negedge clk); guard++; end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int h0;
    rst_n = 1'b0; acc_valid = 0; acc_idx = '0; acc_fetch = 0; acc_write = 0;
    trap_enter = 0; trap_return = 0; ret_persist = 0; save_cmd = 0;
    pw_en = 0; pw_idx = '0; pw_data = '0; rdy_mode = 1; alw_a = '0; alw_b = '0;
    for (int r = 0; r < NREG; r++) begin
      rf[r] = (r == 0) ? 32'h0 : 32'hA000_0000 + r;
      task_m[r] = 32'hF00D_0000 + r;
      hdl_m[r] = 32'hB000_0000 + r;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!stall && !mem_valid && !nest_err && !sweep_done, "R1 idle after reset",
        {stall, mem_valid, nest_err, sweep_done}, 32'h0);

    // ---- invocation 1: demand before sweep, discard return
    push(1'b1, TB_TASK + 32'h14, 32'hA000_0005, "R3 demand save first");
    push(1'b0, TB_HDL + 32'h14, 32'h0, "R4 handler load");
    pulse_enter();
    access(5, 1'b1, 1'b0, 32'h0);
    chk(rf[5] == 32'hB000_0005, "R4 read sees handler value", rf[5], 32'hB000_0005);
    h0 = hdl_reads;
    access(7, 1'b0, 1'b1, 32'h0000_0077);
    chk(hdl_reads == h0, "R11 full write no load", hdl_reads, h0);
    access(9, 1'b1, 1'b1, 32'h0000_0099);
    chk(rf[9] == 32'hB000_0099, "R4 partial write merges handler value", rf[9], 32'hB000_0099);
    wait_done();
    chk(sweep_done, "R5 sweep completes", sweep_done, 1);
    begin
      bit ok = 1'b1;
      for (int r = 1; r < NREG; r++) if (task_m[r] != 32'hA000_0000 + r) ok = 1'b0;
      chk(ok, "R2 task area holds pre-handler values", task_m[7], 32'hA000_0007);
    end
    chk(task_m[0] == 32'hF00D_0000, "R10 slot zero untouched", task_m[0], 32'hF00D_0000);
    pulse_enter();
    chk(nest_err && sweep_done, "R9 nested entry flagged, flags kept", {nest_err, sweep_done}, 32'h3);
    @(negedge clk);
    chk(!nest_err, "R9 error is one cycle", nest_err, 0);
    rdy_mode = 0;
    for (int r = 1; r < NREG; r++) push(1'b0, TB_TASK + 32'(r * 4), 32'h0, "R6 ascending reload");
    ret_persist = 1'b0; trap_return = 1'b1; @(negedge clk); trap_return = 1'b0; rdy_mode = 1;
    drain(4);
    chk(rf[7] == 32'hA000_0007 && rf[9] == 32'hA000_0009, "R6 task values restored", rf[7], 32'hA000_0007);
    chk(hdl_m[7] == 32'hB000_0007, "R7 discard leaves handler area", hdl_m[7], 32'hB000_0007);

    // ---- invocation 2: partial save, persistent return
    rdy_mode = 2; alw_a = TB_TASK + 32'h0C; alw_b = TB_TASK + 32'h0C;
    pulse_enter();
    chk(!sweep_done, "R1 entry clears saved flags", sweep_done, 0);
    h0 = hdl_reads;
    access(3, 1'b0, 1'b1, 32'h0000_0033);
    chk(hdl_reads == h0, "R11 full write no load", hdl_reads, h0);
    alw_a = TB_TASK + 32'h10; alw_b = TB_HDL + 32'h10;
    access(4, 1'b1, 1'b0, 32'h0);
    chk(rf[4] == 32'hB000_0004, "R4 load on read", rf[4], 32'hB000_0004);
    chk(!sweep_done, "R5 not done while slots unsaved", sweep_done, 0);
    task_m[10] = 32'h0000_5555;
    task_m[3]  = 32'h0000_00C3;
    rdy_mode = 0;
    push(1'b1, TB_HDL + 32'h0C, 32'h0000_0033, "R7 persist write");
    push(1'b0, TB_TASK + 32'h0C, 32'h0, "R6 reload r3");
    push(1'b0, TB_TASK + 32'h10, 32'h0, "R6 reload r4");
    ret_persist = 1'b1; trap_return = 1'b1; @(negedge clk); trap_return = 1'b0; rdy_mode = 1;
    drain(80);
    chk(hdl_m[3] == 32'h0000_0033, "R7 persist stored", hdl_m[3], 32'h33);
    chk(rf[3] == 32'h0000_00C3, "R6 saved slot reloaded", rf[3], 32'hC3);
    chk(rf[10] == 32'hA000_000A, "R6 unsaved slot ignored", rf[10], 32'hA000_000A);
    chk(rf[4] == 32'hA000_0004, "R6 r4 reloaded", rf[4], 32'hA000_0004);

    // ---- invocation 3: persistence across calls, explicit save
    rdy_mode = 2; alw_a = TB_TASK + 32'h18; alw_b = TB_TASK + 32'h18;
    pulse_enter();
    access(6, 1'b0, 1'b1, 32'h0000_0066);
    alw_a = TB_TASK + 32'h0C; alw_b = TB_HDL + 32'h0C;
    access(3, 1'b1, 1'b0, 32'h0);
    chk(rf[3] == 32'h0000_0033, "R4 value persists across invocations", rf[3], 32'h33);
    rdy_mode = 0;
    push(1'b1, TB_HDL + 32'h18, 32'h0000_0066, "R8 explicit save");
    save_cmd = 1'b1; @(negedge clk); save_cmd = 1'b0; rdy_mode = 1;
    drain(2);
    chk(hdl_m[6] == 32'h0000_0066, "R8 handler area updated", hdl_m[6], 32'h66);
    wait_done();
    chk(sweep_done, "R5 sweep resumes after save", sweep_done, 1);
    rdy_mode = 0;
    for (int r = 1; r < NREG; r++) push(1'b0, TB_TASK + 32'(r * 4), 32'h0, "R6 ascending reload");
    ret_persist = 1'b0; trap_return = 1'b1; @(negedge clk); trap_return = 1'b0; rdy_mode = 1;
    drain(4);
    chk(rf[6] == 32'hA000_0006, "R7 discard restores task value", rf[6], 32'hA000_0006);
    chk(hdl_m[3] == 32'h0000_0033 && hdl_m[6] == 32'h0000_0066, "R7 discard keeps handler area",
        hdl_m[6], 32'h66);
    chk(hdl_m[0] == 32'hB000_0000 && rf[0] == 32'h0, "R10 register zero untouched", hdl_m[0], 32'hB000_0000);
    chk(!stall && !mem_valid, "R1 idle after return", {stall, mem_valid}, 32'h0);

    summary();
    $finish;
  end
endmodule